// File: doc/BRIEF.md
# Relocatable I/O Window Decoder

This block keeps a small set of configuration bytes that place two 64-byte I/O windows anywhere in a 16-bit I/O space. One window is for power-management registers and the other is for an SMBus host controller. Each window has a base field and an enable bit. Software sets them with byte-enabled configuration writes to a dword address. The block then decodes every I/O address against both windows and reports, for each window, a hit flag and the offset of the address inside that window.

The effective window settings are shadow copies. They are refreshed only when a configuration write lands on that window's base dword or on its enable byte. A two-state controller does the refresh. In `ST_IDLE` nothing is pending. A qualifying write moves it to `ST_APPLY` (transition *arm*). In `ST_APPLY` the dirty shadows load from the stored bytes. Another qualifying write in that cycle keeps it in `ST_APPLY` (transition *rearm*). Otherwise it returns to `ST_IDLE` (transition *retire*). A write that qualifies for neither window leaves it in `ST_IDLE` (transition *hold*). A new setting therefore reaches the decode outputs from the second clock edge after the write.

Implemented configuration dwords, by byte address, are 0x40 (PM base), 0x80 (PM control), 0x90 (SMBus base) and 0xD0 (SMBus control). All other dwords read as zero and ignore writes.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, dword 0x40 reads 0x00000001 and dword 0x80 reads 0, so the PM window is disabled. Dword 0x90 reads {16'h0, SMB_RESET_BASE[15:0] | 1}. Dword 0xD0 reads 0x00090000, so the SMBus window is enabled at base SMB_RESET_BASE & 0xFFC0.
- R2: A write with `cfg_wr` high stores exactly the bytes whose `cfg_be` bit is set (lane n is byte address 4*dw+n) in the four implemented dwords. A read returns the stored dword. Dwords that are not implemented read zero and keep nothing.
- R3: Bit 0 of byte 0x40 always reads 1, whatever was written to it.
- R4: The PM window base is the 16-bit little-endian value at bytes 0x40..0x41 ANDed with 0xFFC0, and bytes 0x42..0x43 have no effect. Its enable is bit 0 of byte 0x80. `pm_hit` is 1 exactly when the window is enabled and io_addr & 0xFFC0 equals the base. `pm_off` is io_addr[5:0] on a hit.
- R5: The SMBus window works the same way, with its base at bytes 0x90..0x91 and its enable at bit 0 of byte 0xD2.
- R6: A qualifying write sampled at clock edge N changes the decode outputs only after edge N+1. Between edges N and N+1 the old window still decodes.
- R7: Writes that touch neither a window's base dword nor its enable byte (bytes 0x81..0x83, 0xD0, 0xD1, 0xD3, or dwords that are not implemented) leave both windows unchanged.
- R8: When both windows cover an address, `pm_hit` is 1 and `smb_hit` is 0.
- R9: An offset output is zero whenever its hit flag is 0.
- R10: Qualifying writes on consecutive cycles are applied in order. After the first write's edge plus one, the first setting decodes. One cycle later, the second setting decodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Write dword address (byte address / 4) |
| cfg_be | input | 4 | Write byte enables, lane n = byte 4*dw+n |
| cfg_wdata | input | 32 | Write data, little-endian lanes |
| cfg_rd_dw | input | 6 | Read dword address |
| cfg_rdata | output | 32 | Read data (combinational) |
| io_addr | input | IO_AW | I/O address to decode |
| pm_hit | output | 1 | Address falls in the PM window |
| pm_off | output | WIN_BITS | Offset inside the PM window |
| smb_hit | output | 1 | Address falls in the SMBus window, and not in the PM window |
| smb_off | output | WIN_BITS | Offset inside the SMBus window |

## Verification
The bench uses the default parameters: a 16-bit I/O space, 64-byte windows and an SMBus reset base of 0x0B00. With these values each window has only 1024 possible bases, so the bench visits every base of both windows. At each base it probes the first and last byte inside the window and the bytes just outside it, including the wrap at both ends of the address space. The same small configuration makes the overlap between the two windows, the read-only indicator bit, the masked upper base bytes and the one-cycle refresh lag cheap to hit directly.

// File: rtl/iowin_pkg.sv
`timescale 1ns/1ps
package iowin_pkg;
    // Implemented configuration dwords (byte address / 4)
    localparam logic [5:0] DW_PM_BASE  = 6'h10;
    localparam logic [5:0] DW_PM_CTL   = 6'h20;
    localparam logic [5:0] DW_SMB_BASE = 6'h24;
    localparam logic [5:0] DW_SMB_CTL  = 6'h34;

    // Byte lane holding each enable bit within its control dword
    localparam int LANE_PM_EN  = 0;
    localparam int LANE_SMB_EN = 2;

    localparam int NUM_SLOTS     = 4;
    localparam int SLOT_PM_BASE  = 0;
    localparam int SLOT_PM_CTL   = 1;
    localparam int SLOT_SMB_BASE = 2;
    localparam int SLOT_SMB_CTL  = 3;

    typedef enum logic {ST_IDLE, ST_APPLY} sync_state_e;

    function automatic logic [5:0] slot_dword(int idx);
        case (idx)
            SLOT_PM_BASE:  return DW_PM_BASE;
            SLOT_PM_CTL:   return DW_PM_CTL;
            SLOT_SMB_BASE: return DW_SMB_BASE;
            default:       return DW_SMB_CTL;
        endcase
    endfunction
endpackage

// File: rtl/iowin_cfg_regs.sv
`timescale 1ns/1ps
module iowin_cfg_regs
    import iowin_pkg::*;
#(
    parameter int          IO_AW          = 16,
    parameter int          WIN_BITS       = 6,
    parameter logic [31:0] SMB_RESET_BASE = 32'h0000_0B00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [5:0]                wr_dw,
    input  logic [3:0]                wr_be,
    input  logic [31:0]               wr_data,
    input  logic [5:0]                rd_dw,
    output logic [31:0]               rd_data,
    output logic [IO_AW-WIN_BITS-1:0] pm_base_bits,
    output logic                      pm_en_bit,
    output logic [IO_AW-WIN_BITS-1:0] smb_base_bits,
    output logic                      smb_en_bit
);
    function automatic logic [31:0] slot_reset(int idx);
        case (idx)
            SLOT_PM_BASE:  return 32'h0000_0001;
            SLOT_SMB_BASE: return {16'h0000, SMB_RESET_BASE[15:0] | 16'h0001};
            SLOT_SMB_CTL:  return 32'h0000_0009 << (8 * LANE_SMB_EN);
            default:       return 32'h0000_0000;
        endcase
    endfunction

    logic [31:0] slot_val [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [5:0]  SLOT_DW  = slot_dword(s);
        localparam logic [31:0] SLOT_RST = slot_reset(s);
        logic [31:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= SLOT_RST;
            end else if (wr_en && wr_dw == SLOT_DW) begin
                for (int b = 0; b < 4; b++) begin
                    if (wr_be[b]) q[8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end

        assign slot_val[s] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_dw == slot_dword(s)) rd_data = slot_val[s];
        end
        // indicator bit of the PM base byte is fixed at one
        if (rd_dw == DW_PM_BASE) rd_data[0] = 1'b1;
    end

    assign pm_base_bits  = slot_val[SLOT_PM_BASE][IO_AW-1:WIN_BITS];
    assign pm_en_bit     = slot_val[SLOT_PM_CTL][8*LANE_PM_EN];
    assign smb_base_bits = slot_val[SLOT_SMB_BASE][IO_AW-1:WIN_BITS];
    assign smb_en_bit    = slot_val[SLOT_SMB_CTL][8*LANE_SMB_EN];
endmodule

// File: rtl/iowin_sync_fsm.sv
`timescale 1ns/1ps
module iowin_sync_fsm
    import iowin_pkg::*;
#(
    parameter int          IO_AW          = 16,
    parameter int          WIN_BITS       = 6,
    parameter logic [31:0] SMB_RESET_BASE = 32'h0000_0B00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [5:0]                wr_dw,
    input  logic [3:0]                wr_be,
    input  logic [IO_AW-WIN_BITS-1:0] pm_base_bits,
    input  logic                      pm_en_bit,
    input  logic [IO_AW-WIN_BITS-1:0] smb_base_bits,
    input  logic                      smb_en_bit,
    output logic [IO_AW-WIN_BITS-1:0] pm_base,
    output logic                      pm_en,
    output logic [IO_AW-WIN_BITS-1:0] smb_base,
    output logic                      smb_en
);
    sync_state_e state_q, state_nxt;
    logic        pm_dirty_q, smb_dirty_q;
    logic        touch_pm, touch_smb;
    logic        load_pm, load_smb;

    // A write qualifies if it lands on the base dword or the enable byte
    assign touch_pm  = wr_en && ((wr_dw == DW_PM_BASE && |wr_be) ||
                                 (wr_dw == DW_PM_CTL  && wr_be[LANE_PM_EN]));
    assign touch_smb = wr_en && ((wr_dw == DW_SMB_BASE && |wr_be) ||
                                 (wr_dw == DW_SMB_CTL  && wr_be[LANE_SMB_EN]));

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:  state_nxt = (touch_pm || touch_smb) ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_nxt = (touch_pm || touch_smb) ? ST_APPLY : ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pm_dirty_q  <= 1'b0;
            smb_dirty_q <= 1'b0;
        end else begin
            state_q     <= state_nxt;
            pm_dirty_q  <= touch_pm;
            smb_dirty_q <= touch_smb;
        end
    end

    always_comb begin
        load_pm  = 1'b0;
        load_smb = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_APPLY: begin
                load_pm  = pm_dirty_q;
                load_smb = smb_dirty_q;
            end
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_en    <= 1'b0;
            pm_base  <= '0;
            smb_en   <= 1'b1;
            smb_base <= SMB_RESET_BASE[IO_AW-1:WIN_BITS];
        end else begin
            if (load_pm) begin
                pm_en   <= pm_en_bit;
                pm_base <= pm_base_bits;
            end
            if (load_smb) begin
                smb_en   <= smb_en_bit;
                smb_base <= smb_base_bits;
            end
        end
    end
endmodule

// File: rtl/iowin_window_match.sv
`timescale 1ns/1ps
module iowin_window_match #(
    parameter int IO_AW    = 16,
    parameter int WIN_BITS = 6
) (
    input  logic                      en,
    input  logic [IO_AW-WIN_BITS-1:0] base,
    input  logic [IO_AW-1:0]          addr,
    output logic                      match,
    output logic [WIN_BITS-1:0]       off
);
    assign match = en && (addr[IO_AW-1:WIN_BITS] == base);
    assign off   = match ? addr[WIN_BITS-1:0] : '0;
endmodule

// File: rtl/iowin_decoder.sv
`timescale 1ns/1ps
module iowin_decoder #(
    parameter int          IO_AW          = 16,
    parameter int          WIN_BITS       = 6,
    parameter logic [31:0] SMB_RESET_BASE = 32'h0000_0B00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [5:0]          cfg_dw,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    input  logic [5:0]          cfg_rd_dw,
    output logic [31:0]         cfg_rdata,
    input  logic [IO_AW-1:0]    io_addr,
    output logic                pm_hit,
    output logic [WIN_BITS-1:0] pm_off,
    output logic                smb_hit,
    output logic [WIN_BITS-1:0] smb_off
);
    localparam int BW = IO_AW - WIN_BITS;

    logic [BW-1:0]       pm_base_bits, smb_base_bits, pm_base, smb_base;
    logic                pm_en_bit, smb_en_bit, pm_en, smb_en;
    logic                pm_match, smb_match;
    logic [WIN_BITS-1:0] pm_off_raw, smb_off_raw;

    iowin_cfg_regs #(
        .IO_AW(IO_AW), .WIN_BITS(WIN_BITS), .SMB_RESET_BASE(SMB_RESET_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_dw(cfg_dw), .wr_be(cfg_be), .wr_data(cfg_wdata),
        .rd_dw(cfg_rd_dw), .rd_data(cfg_rdata),
        .pm_base_bits(pm_base_bits), .pm_en_bit(pm_en_bit),
        .smb_base_bits(smb_base_bits), .smb_en_bit(smb_en_bit)
    );

    iowin_sync_fsm #(
        .IO_AW(IO_AW), .WIN_BITS(WIN_BITS), .SMB_RESET_BASE(SMB_RESET_BASE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_dw(cfg_dw), .wr_be(cfg_be),
        .pm_base_bits(pm_base_bits), .pm_en_bit(pm_en_bit),
        .smb_base_bits(smb_base_bits), .smb_en_bit(smb_en_bit),
        .pm_base(pm_base), .pm_en(pm_en),
        .smb_base(smb_base), .smb_en(smb_en)
    );

    iowin_window_match #(.IO_AW(IO_AW), .WIN_BITS(WIN_BITS)) u_pm_match (
        .en(pm_en), .base(pm_base), .addr(io_addr),
        .match(pm_match), .off(pm_off_raw)
    );

    iowin_window_match #(.IO_AW(IO_AW), .WIN_BITS(WIN_BITS)) u_smb_match (
        .en(smb_en), .base(smb_base), .addr(io_addr),
        .match(smb_match), .off(smb_off_raw)
    );

    // PM window wins on overlap
    assign pm_hit  = pm_match;
    assign pm_off  = pm_off_raw;
    assign smb_hit = smb_match && !pm_match;
    assign smb_off = pm_match ? '0 : smb_off_raw;
endmodule

// File: rtl/iowin_decoder_chk.sv
`timescale 1ns/1ps
module iowin_decoder_chk
    import iowin_pkg::*;
#(
    parameter int IO_AW    = 16,
    parameter int WIN_BITS = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr,
    input logic [5:0]          cfg_rd_dw,
    input logic                rd_bit0,
    input logic [IO_AW-1:0]    io_addr,
    input logic                pm_hit,
    input logic [WIN_BITS-1:0] pm_off,
    input logic                smb_hit,
    input logic [WIN_BITS-1:0] smb_off
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    assert_pm_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smb_hit |-> !pm_hit);

    assert_ro_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_dw == DW_PM_BASE) |-> rd_bit0);

    assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pm_hit |-> pm_off == '0) and (!smb_hit |-> smb_off == '0));

    assert_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && !$past(cfg_wr) && !$past(cfg_wr, 2) && $stable(io_addr))
        |-> ($stable(pm_hit) && $stable(smb_hit) && $stable(pm_off) && $stable(smb_off)));

    assert_open_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && ($rose(pm_hit) || $rose(smb_hit)) && $stable(io_addr))
        |-> $past(cfg_wr, 2));
endmodule

bind iowin_decoder iowin_decoder_chk #(.IO_AW(IO_AW), .WIN_BITS(WIN_BITS)) u_iowin_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd_dw(cfg_rd_dw),
    .rd_bit0(cfg_rdata[0]), .io_addr(io_addr),
    .pm_hit(pm_hit), .pm_off(pm_off), .smb_hit(smb_hit), .smb_off(smb_off)
);

// File: tb/test_iowin_decoder.sv
`timescale 1ns/1ps
module test_iowin_decoder;
    localparam int          IO_AW    = 16;
    localparam int          WIN_BITS = 6;
    localparam logic [31:0] SMB_INIT = 32'h0000_0B00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  cfg_rd_dw = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit;
    logic [5:0]  pm_off, smb_off;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0]  mdl [256];
    logic        a_pm_en, a_smb_en;
    logic [15:0] a_pm_base, a_smb_base;

    always #5 clk = ~clk;

    iowin_decoder #(.IO_AW(IO_AW), .WIN_BITS(WIN_BITS), .SMB_RESET_BASE(SMB_INIT)) i_iowin_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rd_dw(cfg_rd_dw), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .pm_hit(pm_hit), .pm_off(pm_off),
        .smb_hit(smb_hit), .smb_off(smb_off)
    );

    function automatic bit is_impl(logic [5:0] dw);
        return dw == 6'h10 || dw == 6'h20 || dw == 6'h24 || dw == 6'h34;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        mdl[8'h40] = 8'h01;
        mdl[8'h90] = SMB_INIT[7:0] | 8'h01;
        mdl[8'h91] = SMB_INIT[15:8];
        mdl[8'hD2] = 8'h09;
    endtask

    task automatic sync_model();
        a_pm_en    = mdl[8'h80][0];
        a_pm_base  = {mdl[8'h41], mdl[8'h40]} & 16'hFFC0;
        a_smb_en   = mdl[8'hD2][0];
        a_smb_base = {mdl[8'h91], mdl[8'h90]} & 16'hFFC0;
    endtask

    task automatic model_write(logic [5:0] dw, logic [3:0] be, logic [31:0] data);
        if (is_impl(dw)) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) mdl[{dw, 2'(b)}] = data[8*b +: 8];
            end
        end
    endtask

    task automatic cfg_write(logic [5:0] dw, logic [3:0] be, logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_write(dw, be, data);
    endtask

    task automatic put(logic [5:0] dw, logic [3:0] be, logic [31:0] data);
        cfg_write(dw, be, data);
        @(negedge clk);
        sync_model();
    endtask

    task automatic report(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_io_now(logic [15:0] a, string req);
        logic pm_m, smb_m;
        logic [13:0] exp, act;
        io_addr = a;
        #2;
        pm_m  = a_pm_en && ((a & 16'hFFC0) == a_pm_base);
        smb_m = a_smb_en && ((a & 16'hFFC0) == a_smb_base) && !pm_m;
        exp = {pm_m, pm_m ? a[5:0] : 6'd0, smb_m, smb_m ? a[5:0] : 6'd0};
        act = {pm_hit, pm_off, smb_hit, smb_off};
        report(act == exp, $sformatf("%s/R9 addr %h", req, a), 32'(act), 32'(exp));
    endtask

    task automatic check_io(logic [15:0] a, string req);
        @(negedge clk);
        check_io_now(a, req);
    endtask

    task automatic edges4(logic [15:0] base, string req);
        check_io(base - 16'd1, req);
        check_io(base, req);
        check_io(base + 16'd63, req);
        check_io(base + 16'd64, req);
    endtask

    task automatic check_rd(logic [5:0] dw, string req);
        logic [31:0] exp;
        @(negedge clk);
        cfg_rd_dw = dw;
        #2;
        exp = is_impl(dw) ? {mdl[{dw, 2'd3}], mdl[{dw, 2'd2}], mdl[{dw, 2'd1}], mdl[{dw, 2'd0}]} : 32'h0;
        if (dw == 6'h10) exp[0] = 1'b1;
        report(cfg_rdata == exp, $sformatf("%s read dw %h", req, dw), cfg_rdata, exp);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        sync_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents and reset decode
        check_rd(6'h10, "R1");
        check_rd(6'h20, "R1");
        check_rd(6'h24, "R1");
        check_rd(6'h34, "R1");
        edges4(16'h0B00, "R1");
        check_io(16'h0000, "R1");

        // R2: byte-enabled storage, unimplemented dwords
        cfg_write(6'h24, 4'b0100, 32'hAABB_CCDD);
        check_rd(6'h24, "R2");
        cfg_write(6'h3F, 4'b1111, 32'hFFFF_FFFF);
        check_rd(6'h3F, "R2");
        cfg_write(6'h24, 4'b1000, 32'h1234_5678);
        check_rd(6'h24, "R2");
        sync_model();
        edges4(16'h0B00, "R2");

        // R3: read-only indicator bit
        put(6'h10, 4'b0001, 32'h0000_0000);
        check_rd(6'h10, "R3");
        put(6'h10, 4'b0001, 32'h0000_00FE);
        check_rd(6'h10, "R3");

        // R4: enable PM, sweep every PM base
        put(6'h20, 4'b0001, 32'h0000_0001);
        for (int b = 0; b < 1024; b++) begin
            put(6'h10, 4'b0011, {16'h0000, 16'(b << 6) | 16'((b * 37) % 64)});
            edges4(16'(b << 6), "R4");
        end
        put(6'h10, 4'b1100, 32'hDEAD_0000);
        edges4(16'hFFC0, "R4");
        check_io(16'h0000, "R4");

        // R5: disable PM, sweep every SMBus base
        put(6'h20, 4'b0001, 32'h0000_0000);
        for (int b = 0; b < 1024; b++) begin
            put(6'h24, 4'b0011, {16'h0000, 16'(b << 6) | 16'((b * 11) % 64)});
            edges4(16'(b << 6), "R5");
        end
        put(6'h34, 4'b0100, 32'h0000_0000);
        edges4(16'hFFC0, "R5");
        put(6'h34, 4'b0100, 32'h0001_0000);
        edges4(16'hFFC0, "R5");

        // R6: refresh lag of one cycle
        put(6'h10, 4'b0011, 32'h0000_1000);
        put(6'h20, 4'b0001, 32'h0000_0001);
        cfg_write(6'h10, 4'b0011, 32'h0000_2000);
        check_io_now(16'h1005, "R6 old");
        check_io_now(16'h2005, "R6 old");
        @(negedge clk);
        sync_model();
        check_io_now(16'h1005, "R6 new");
        check_io(16'h2005, "R6 new");
        cfg_write(6'h20, 4'b0001, 32'h0000_0000);
        check_io_now(16'h2010, "R6 old");
        @(negedge clk);
        sync_model();
        check_io_now(16'h2010, "R6 new");

        // R7: writes to bytes that select nothing
        put(6'h20, 4'b0001, 32'h0000_0001);
        cfg_write(6'h20, 4'b1110, 32'hFFFF_FF00);
        check_io_now(16'h2001, "R7");
        cfg_write(6'h34, 4'b1011, 32'hFF00_FFFF);
        check_io_now(16'hFFC1, "R7");
        cfg_write(6'h11, 4'b1111, 32'h0000_0000);
        check_io_now(16'h2001, "R7");
        @(negedge clk);
        sync_model();
        check_io_now(16'h2001, "R7");
        check_io(16'hFFC1, "R7");
        check_rd(6'h20, "R7");

        // R8: overlapping windows
        put(6'h10, 4'b0011, 32'h0000_3000);
        put(6'h24, 4'b0011, 32'h0000_3000);
        edges4(16'h3000, "R8");
        put(6'h20, 4'b0001, 32'h0000_0000);
        edges4(16'h3000, "R8");

        // R10: back-to-back qualifying writes
        put(6'h20, 4'b0001, 32'h0000_0001);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = 6'h10; cfg_be = 4'b0011; cfg_wdata = 32'h0000_4000;
        @(negedge clk);
        model_write(6'h10, 4'b0011, 32'h0000_4000);
        cfg_dw = 6'h10; cfg_wdata = 32'h0000_5000;
        @(negedge clk);
        cfg_wr = 1'b0;
        sync_model();
        model_write(6'h10, 4'b0011, 32'h0000_5000);
        check_io_now(16'h4002, "R10 first");
        check_io_now(16'h5002, "R10 first");
        @(negedge clk);
        sync_model();
        check_io_now(16'h4002, "R10 second");
        check_io(16'h5002, "R10 second");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule